// File: doc/BRIEF.md
# Two-Level Password Access Gate

This block decides whether each register access from the host may go ahead. The host writes a 32-bit password-entry register one byte at a time. When the last byte lands, the block compares the whole entry with two stored passwords. That comparison sets the current privilege: none, the lower level or the upper level. The levels are nested, so the upper level grants everything the lower one does.

Each access names either the open lower area or the upper area. In the upper area, a table-select register picks the region. For every region, two permission vectors choose whether the lower or the upper level is needed, one vector for reads and one for writes. The region that holds the stored passwords always needs the upper level.

The result is one registered read-allow or write-allow strobe for the register file. A denied read returns all-ones data and a denied write gets no strobe. The stored passwords, the permission vectors and the power-on table selection come in as inputs. The block holds only the entry register, the privilege level and the table-select register.

Top module: `pwgate_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `priv_level` is 0 (none), `tbl_sel_q` equals `tsel_pon`, both allow strobes are 0 and `rd_data_out` is all ones.
- R2: `ent_byte`=k with `ent_we` high writes `ent_data` into entry bits [8k+7:8k]. The privilege level changes only on a clock edge where byte 3 (the most significant) is written. Writes to bytes 0 to 2 leave `priv_level` unchanged.
- R3: On a byte-3 write, if the updated entry equals `pw2_val`, the level becomes 2 (upper). This holds even when `pw1_val` is the same value.
- R4: On a byte-3 write, if the updated entry equals only `pw1_val`, the level becomes 1 (lower). If it matches neither, the level drops to 0.
- R5: An access with `acc_upper`=0 is allowed at every privilege level, for both reads and writes.
- R6: An upper access to region r = `tbl_sel_q` needs level 2 to read when `rd_need_hi[r]`=1 and level 1 when it is 0. Writes follow the same rule using `wr_need_hi[r]`. A level at or above the need allows the access.
- R7: Region `PW_REGION` needs level 2 for read and write, whatever its permission bits say.
- R8: An upper access with `tbl_sel_q` >= `NUM_REGIONS` is denied for both read and write.
- R9: The result of an access appears on the outputs one cycle after the request. An allowed read passes `rd_data_in`. Otherwise `rd_data_out` is all ones.
- R10: `rd_allow` rises only for a valid read (`acc_write`=0). `wr_allow` rises only for a valid write. With `acc_valid` low, both stay 0.
- R11: A cycle with `tsel_we` high loads `tsel_data` into `tbl_sel_q`. An access in that same cycle still uses the previous selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_we | input | 1 | Write one byte of the password-entry register |
| ent_byte | input | 2 | Byte index of the entry write (3 = most significant) |
| ent_data | input | 8 | Entry byte value |
| tsel_we | input | 1 | Write the table-select register |
| tsel_data | input | 8 | New table selection |
| tsel_pon | input | 8 | Table selection loaded at reset |
| pw1_val | input | 32 | Stored lower-level password |
| pw2_val | input | 32 | Stored upper-level password |
| rd_need_hi | input | NUM_REGIONS | Per region: 1 = reading needs upper level |
| wr_need_hi | input | NUM_REGIONS | Per region: 1 = writing needs upper level |
| acc_valid | input | 1 | An access is requested this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_upper | input | 1 | 1 = upper area via table select, 0 = open lower area |
| rd_data_in | input | 8 | Read data from the register file |
| rd_allow | output | 1 | Registered read permission strobe |
| wr_allow | output | 1 | Registered write permission strobe |
| rd_data_out | output | 8 | Read data, all ones when not allowed |
| priv_level | output | 2 | Current level: 0 none, 1 lower, 2 upper |
| tbl_sel_q | output | 8 | Current table selection |

## Verification
The bench builds the gate with `NUM_REGIONS`=6 and `PW_REGION`=2. The 6 regions do not fill the 3-bit index, so selections 6 and 7 land in the unused slots. The out-of-range denial is therefore exercised both there and far above, at 200. The password region sits in the middle of the table with its permission bits cleared, which shows that its fixed upper-level need overrides those bits. Giving both stored passwords the same value makes the upper-first comparison order visible at the ports.

// File: rtl/pwgate_pkg.sv
package pwgate_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_PW1  = 2'd1,
    LVL_PW2  = 2'd2
  } priv_e;
endpackage

// File: rtl/pwgate_level.sv
module pwgate_level
  import pwgate_pkg::*;
#(
  parameter int PW_BYTES = 4,
  localparam int PW_W = PW_BYTES * 8,
  localparam int BI_W = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ent_we,
  input  logic [BI_W-1:0] ent_byte,
  input  logic [7:0]      ent_data,
  input  logic [PW_W-1:0] pw1_val,
  input  logic [PW_W-1:0] pw2_val,
  output priv_e           level_q
);
  logic [PW_W-1:0] entry_q;
  logic [PW_W-1:0] entry_nxt;
  logic            last_byte;

  for (genvar b = 0; b < PW_BYTES; b++) begin : g_byte
    assign entry_nxt[b*8 +: 8] = (ent_we && ent_byte == BI_W'(b)) ? ent_data
                                                                   : entry_q[b*8 +: 8];
  end

  assign last_byte = ent_we && (ent_byte == BI_W'(PW_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q <= '0;
      level_q <= LVL_NONE;
    end else begin
      entry_q <= entry_nxt;
      if (last_byte) begin
        if (entry_nxt == pw2_val)      level_q <= LVL_PW2;
        else if (entry_nxt == pw1_val) level_q <= LVL_PW1;
        else                           level_q <= LVL_NONE;
      end
    end
  end

  // R2: level moves only on a most-significant-byte write
  p_level_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !last_byte |=> $stable(level_q));

  // R3: upper level is reported only after an entry completion
  p_pw2_after_entry_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(level_q == LVL_PW2) |-> $past(last_byte));
endmodule

// File: rtl/pwgate_perm.sv
module pwgate_perm
  import pwgate_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int PW_REGION   = 2,
  parameter int SEL_W       = 8
) (
  input  logic [SEL_W-1:0]       tbl_sel,
  input  logic [NUM_REGIONS-1:0] rd_need_hi,
  input  logic [NUM_REGIONS-1:0] wr_need_hi,
  input  priv_e                  level,
  output logic                   rd_ok,
  output logic                   wr_ok
);
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int SLOTS = 1 << IDX_W;

  priv_e rd_req [SLOTS];
  priv_e wr_req [SLOTS];
  logic  in_range;
  logic [IDX_W-1:0] idx;

  for (genvar r = 0; r < SLOTS; r++) begin : g_slot
    if (r == PW_REGION) begin : g_pw
      assign rd_req[r] = LVL_PW2;
      assign wr_req[r] = LVL_PW2;
    end else if (r < NUM_REGIONS) begin : g_real
      assign rd_req[r] = rd_need_hi[r] ? LVL_PW2 : LVL_PW1;
      assign wr_req[r] = wr_need_hi[r] ? LVL_PW2 : LVL_PW1;
    end else begin : g_pad
      assign rd_req[r] = LVL_PW2;
      assign wr_req[r] = LVL_PW2;
    end
  end

  assign in_range = 32'(tbl_sel) < 32'(NUM_REGIONS);
  assign idx      = tbl_sel[IDX_W-1:0];
  assign rd_ok    = in_range && (level >= rd_req[idx]);
  assign wr_ok    = in_range && (level >= wr_req[idx]);
endmodule

// File: rtl/pwgate_top.sv
module pwgate_top
  import pwgate_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int PW_REGION   = 2,
  parameter int SEL_W       = 8,
  parameter int DATA_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ent_we,
  input  logic [1:0]             ent_byte,
  input  logic [7:0]             ent_data,
  input  logic                   tsel_we,
  input  logic [SEL_W-1:0]       tsel_data,
  input  logic [SEL_W-1:0]       tsel_pon,
  input  logic [31:0]            pw1_val,
  input  logic [31:0]            pw2_val,
  input  logic [NUM_REGIONS-1:0] rd_need_hi,
  input  logic [NUM_REGIONS-1:0] wr_need_hi,
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic                   acc_upper,
  input  logic [DATA_W-1:0]      rd_data_in,
  output logic                   rd_allow,
  output logic                   wr_allow,
  output logic [DATA_W-1:0]      rd_data_out,
  output logic [1:0]             priv_level,
  output logic [SEL_W-1:0]       tbl_sel_q
);
  priv_e level;
  logic  rd_ok, wr_ok;
  logic  rd_go, wr_go;

  pwgate_level #(.PW_BYTES(4)) u_level (
    .clk      (clk),
    .rst      (rst),
    .ent_we   (ent_we),
    .ent_byte (ent_byte),
    .ent_data (ent_data),
    .pw1_val  (pw1_val),
    .pw2_val  (pw2_val),
    .level_q  (level)
  );

  pwgate_perm #(
    .NUM_REGIONS (NUM_REGIONS),
    .PW_REGION   (PW_REGION),
    .SEL_W       (SEL_W)
  ) u_perm (
    .tbl_sel    (tbl_sel_q),
    .rd_need_hi (rd_need_hi),
    .wr_need_hi (wr_need_hi),
    .level      (level),
    .rd_ok      (rd_ok),
    .wr_ok      (wr_ok)
  );

  assign rd_go = acc_valid && !acc_write && (!acc_upper || rd_ok);
  assign wr_go = acc_valid &&  acc_write && (!acc_upper || wr_ok);
  assign priv_level = level;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_sel_q   <= tsel_pon;
      rd_allow    <= 1'b0;
      wr_allow    <= 1'b0;
      rd_data_out <= '1;
    end else begin
      if (tsel_we) tbl_sel_q <= tsel_data;
      rd_allow    <= rd_go;
      wr_allow    <= wr_go;
      rd_data_out <= rd_go ? rd_data_in : '1;
    end
  end

  // R10: no strobe without a request
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !rd_allow && !wr_allow);

  // R5: lower area always readable
  p_lower_open_r5: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_upper && !acc_write |=> rd_allow);

  // R8: out-of-range selection denied
  p_oob_deny_r8: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_upper && (32'(tbl_sel_q) >= 32'(NUM_REGIONS)) |=> !rd_allow && !wr_allow);

  // R7: password region needs upper level
  p_pw_region_r7: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_upper && (32'(tbl_sel_q) == 32'(PW_REGION)) && level != LVL_PW2
      |=> !rd_allow && !wr_allow);
endmodule

// File: tb/pwgate_top_tb.sv
module pwgate_top_tb;
  localparam int NR = 6;
  localparam int PWR = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ent_we = 1'b0;
  logic [1:0] ent_byte = '0;
  logic [7:0] ent_data = '0;
  logic tsel_we = 1'b0;
  logic [7:0] tsel_data = '0;
  logic [7:0] tsel_pon = 8'd4;
  logic [31:0] pw1_val = 32'h1111_2222;
  logic [31:0] pw2_val = 32'h3333_4444;
  logic [NR-1:0] rd_need_hi = 6'b00_0010;
  logic [NR-1:0] wr_need_hi = 6'b00_0001;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_upper = 1'b0;
  logic [7:0] rd_data_in = '0;
  logic rd_allow, wr_allow;
  logic [7:0] rd_data_out;
  logic [1:0] priv_level;
  logic [7:0] tbl_sel_q;

  always #2 clk = ~clk;

  pwgate_top #(.NUM_REGIONS(NR), .PW_REGION(PWR), .SEL_W(8), .DATA_W(8)) u_dut (
    .clk(clk), .rst(rst), .ent_we(ent_we), .ent_byte(ent_byte), .ent_data(ent_data),
    .tsel_we(tsel_we), .tsel_data(tsel_data), .tsel_pon(tsel_pon),
    .pw1_val(pw1_val), .pw2_val(pw2_val), .rd_need_hi(rd_need_hi), .wr_need_hi(wr_need_hi),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_upper(acc_upper), .rd_data_in(rd_data_in),
    .rd_allow(rd_allow), .wr_allow(wr_allow), .rd_data_out(rd_data_out),
    .priv_level(priv_level), .tbl_sel_q(tbl_sel_q));

  int checks = 0, failures = 0;
  string tag = "R1";
  logic [31:0] m_entry;
  int m_level, m_tsel;
  bit e_rd, e_wr;
  logic [7:0] e_data;

  function automatic int need(input int sel, input bit hi);
    if (sel == PWR) return 2;
    return hi ? 2 : 1;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("rd_allow", int'(rd_allow), int'(e_rd));
    chk("wr_allow", int'(wr_allow), int'(e_wr));
    chk("rd_data_out", int'(rd_data_out), int'(e_data));
    chk("priv_level", int'(priv_level), m_level);
    chk("tbl_sel_q", int'(tbl_sel_q), m_tsel);
  endtask

  task automatic cyc(input bit ev, input int eb, input logic [7:0] ed,
                     input bit tv, input logic [7:0] td,
                     input bit av, input bit aw, input bit au, input logic [7:0] rdi);
    bit ok;
    ent_we = ev; ent_byte = 2'(eb); ent_data = ed;
    tsel_we = tv; tsel_data = td;
    acc_valid = av; acc_write = aw; acc_upper = au; rd_data_in = rdi;
    @(posedge clk);
    ok = 1'b1;
    if (au) begin
      if (m_tsel >= NR) ok = 1'b0;
      else ok = m_level >= need(m_tsel, aw ? wr_need_hi[m_tsel] : rd_need_hi[m_tsel]);
    end
    e_rd = av && !aw && ok;
    e_wr = av && aw && ok;
    e_data = e_rd ? rdi : 8'hFF;
    if (tv) m_tsel = int'(td);
    if (ev) begin
      m_entry[eb*8 +: 8] = ed;
      if (eb == 3) begin
        if (m_entry == pw2_val) m_level = 2;
        else if (m_entry == pw1_val) m_level = 1;
        else m_level = 0;
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic enter(input logic [31:0] v);
    for (int b = 0; b < 4; b++) cyc(1, b, v[b*8 +: 8], 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input bit up, input logic [7:0] d); cyc(0,0,0,0,0,1,0,up,d); endtask
  task automatic wr(input bit up); cyc(0,0,0,0,0,1,1,up,8'h5A); endtask
  task automatic sel(input logic [7:0] s); cyc(0,0,0,1,s,0,0,0,0); endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 5000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    m_entry = '0; m_level = 0; m_tsel = 4;
    e_rd = 0; e_wr = 0; e_data = 8'hFF;
    // R1 reset state
    tag = "R1";
    repeat (3) begin @(posedge clk); @(negedge clk); compare(); end
    rst = 1'b0;
    cyc(0,0,0,0,0,0,0,0,0);
    // R5 lower area open at level none
    tag = "R5"; rd(0, 8'h3C); wr(0);
    // R6/R9 upper region 4 denied at none, data all ones
    tag = "R9"; rd(1, 8'h77); wr(1);
    // R2 partial entry keeps level
    tag = "R2";
    for (int b = 0; b < 3; b++) cyc(1, b, pw1_val[b*8 +: 8], 0, 0, 0, 0, 0, 0);
    chk("level after 3 bytes", int'(priv_level), 0);
    // R4 last byte gives lower level
    tag = "R4"; cyc(1, 3, pw1_val[31:24], 0, 0, 0, 0, 0, 0);
    chk("level pw1", int'(priv_level), 1);
    // R11 table select, R6 per-region rules
    tag = "R11"; sel(8'd0);
    tag = "R6"; rd(1, 8'h11); wr(1);
    sel(8'd1); rd(1, 8'h22); wr(1);
    // R7 password region at lower level
    tag = "R7"; sel(8'd2); rd(1, 8'h33); wr(1);
    // R8 out of range
    tag = "R8"; sel(8'd6); rd(1, 8'h44); wr(1); sel(8'd200); rd(1, 8'h45);
    // R11 select and access in same cycle uses old selection
    tag = "R11"; cyc(0,0,0,1,8'd3,1,0,1,8'h66); rd(1, 8'h67);
    // R3 upper level
    tag = "R3"; enter(pw2_val);
    chk("level pw2", int'(priv_level), 2);
    sel(8'd2); rd(1, 8'h88); wr(1); sel(8'd1); rd(1, 8'h89); wr(1);
    tag = "R8"; sel(8'd7); rd(1, 8'h8A); wr(1);
    // R10 direction and idle
    tag = "R10"; cyc(0,0,0,0,0,0,0,1,8'h12); cyc(0,0,0,0,0,0,1,0,8'h13); wr(0); rd(0, 8'h14);
    // R4 wrong entry drops level
    tag = "R4"; enter(32'hDEAD_BEEF);
    chk("level dropped", int'(priv_level), 0);
    sel(8'd0); rd(1, 8'h9A);
    // R3 equal passwords: upper wins
    tag = "R3"; pw1_val = 32'hCAFE_F00D; pw2_val = 32'hCAFE_F00D;
    enter(32'hCAFE_F00D);
    chk("equal pw level", int'(priv_level), 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule